// File: doc/BRIEF.md
# Packet command decoder with interrupt stall

This block sits at the front of a vertex-data packet engine. It reads 32-bit command words from a small internal word queue, which is filled through a valid/ready stream. It decodes each command and updates the engine's configuration registers. Most commands carry an immediate value. A few also take operand words that follow them in the stream. Such a command is held until all of its operands are present in the queue.

Each command word can carry an interrupt flag. The flag is checked in one central place before the command does anything. A flagged command stalls the pipeline and raises an interrupt-pending output. The only command that still takes effect while stalled is the marker write. After the interrupt is acknowledged, the held command is decoded again with its flag disregarded, so it completes normally.

The parameter UNIT chooses between two variants. Unit 1 accepts the full command set. Unit 0 treats the offset, base, path-mask, full-flush and forced-call commands as errors. Flush and call waits are reduced to two busy inputs.

Command word layout: bit 31 is the interrupt flag, bits 30:24 are the command code, bits 23:16 are the count and bits 15:0 are the immediate. A word is accepted on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` is low only while the queue holds FIFO_DEPTH words. A producer facing a low `in_ready` keeps the same word on `in_data` with `in_valid` high.

Top module: `cmd_decode_engine`

## Requirements
- R1: A word is taken into the queue on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low exactly when the queue holds FIFO_DEPTH words.
- R2: `pipe_state` encodes the pipeline as follows: 0 idle, 1 decode, 2 waiting for operands or busy, 3 stall. When the state is idle and the queue is not empty, the next state is decode. A command that completes or fails returns the state to idle and adds its word count (command plus operands) to `cmd_ptr`. The low two bits of `cmd_ptr` give the word position within a four-word quadword.
- R3: A command decoded with bit 31 set, and not yet acknowledged, sets `irq_pend` and enters the stall state. It changes no register other than the marker, and consumes nothing while stalled.
- R4: The marker command (code 0x07) writes its immediate into `mark_val`, even when its interrupt flag causes a stall.
- R5: In the stall state, `irq_ack` clears `irq_pend` and moves the state to decode on the next edge. The held command then executes without stalling again. `irq_ack` has no effect in any other state.
- R6: The cycle command (code 0x01) loads immediate bits 15:8 into `cyc_wl` and bits 7:0 into `cyc_cl`.
- R7: The following commands load fields from their immediate:
  - Offset (0x02) loads immediate bits 9:0 into `ofs_val` and clears `dbuf_flag`.
  - Base (0x03) loads immediate bits 9:0 into `base_val`.
  - Item-top (0x04) loads immediate bits 9:0 into `itop_val`.
  - Mode (0x05) loads immediate bits 1:0 into `mode_val`.
  - Path mask (0x06) loads immediate bit 15 into `path3_mask`.
  - No-op (0x00) only advances.
- R8: On unit 0, the codes 0x02, 0x03, 0x06, 0x11, 0x13 and 0x15 each do the same: they pulse `err_pulse` for one cycle, change no register and consume their word.
- R9: The mask load (0x20) needs 1 operand word and loads `mask_val`. The row load (0x30) and column load (0x31) each need 4 operand words. They load `row_val` / `col_val`, with the first operand in bits 31:0 and the fourth in bits 127:96. While the operands are missing, the state is 2 and `cmd_ptr` holds.
- R10: The following commands hold in state 2 while any busy input they need is high:
  - VU flush (0x10) needs `vu_busy` low.
  - Full flushes (0x11, 0x13) need both `vu_busy` and `gfx_busy` low.
  - Call (0x14) needs `vu_busy` low.
  - Forced call (0x15) needs both busy inputs low.
  - Continue (0x17) needs `vu_busy` low.
  - Call and forced call toggle `dbuf_flag` when they complete.
- R11: The upload command (0x4A) is legal only at word position 1 or 3. It loads `xfer_len` with its count, where 0 means 256. The transfer commands (0x50, 0x51) are legal only at word position 3. They load `xfer_len` with their immediate, where 0 means 65536. A misplaced command pulses `err_pulse` and is consumed.
- R12: Any code not listed above pulses `err_pulse` for one cycle, changes no register and is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command/operand word offered |
| in_ready | output | 1 | Queue can take a word |
| in_data | input | 32 | Command or operand word |
| irq_ack | input | 1 | Interrupt acknowledge, releases a stall |
| vu_busy | input | 1 | Vector unit busy (stub) |
| gfx_busy | input | 1 | Graphics path busy (stub) |
| pipe_state | output | 2 | Pipeline state |
| irq_pend | output | 1 | Interrupt pending |
| err_pulse | output | 1 | One-cycle error indication |
| cmd_ptr | output | PTR_W | Words consumed so far |
| cyc_wl | output | 8 | Write-length field |
| cyc_cl | output | 8 | Cycle-length field |
| ofs_val | output | 10 | Offset register |
| dbuf_flag | output | 1 | Double-buffer flag |
| base_val | output | 10 | Base register |
| itop_val | output | 10 | Item-top register |
| mode_val | output | 2 | Mode register |
| mark_val | output | 16 | Marker register |
| path3_mask | output | 1 | Path mask bit |
| mask_val | output | 32 | Write mask register |
| row_val | output | 128 | Row fill register |
| col_val | output | 128 | Column fill register |
| xfer_len | output | 17 | Decoded upload/transfer length |

## Verification
The bench builds two copies of the block, both with FIFO_DEPTH of 8.

The first copy uses UNIT=1 and runs against a behavioural model that is compared on every clock. This shallow queue lets a single blocked flush fill the queue, so `in_ready` back-pressure is exercised. It also means a four-operand load can be seen arriving in parts.

The second copy uses UNIT=0. It makes reachable the error path for commands that are legal only on unit 1, alongside a legal command on the same unit.

// File: rtl/cdec_pkg.sv
package cdec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_WAIT   = 2'd2,
    ST_STALL  = 2'd3
  } pstate_t;

  localparam logic [6:0] C_NOP    = 7'h00;
  localparam logic [6:0] C_CYCLE  = 7'h01;
  localparam logic [6:0] C_OFFSET = 7'h02;
  localparam logic [6:0] C_BASE   = 7'h03;
  localparam logic [6:0] C_ITOP   = 7'h04;
  localparam logic [6:0] C_MODE   = 7'h05;
  localparam logic [6:0] C_PATH   = 7'h06;
  localparam logic [6:0] C_MARK   = 7'h07;
  localparam logic [6:0] C_FLVU   = 7'h10;
  localparam logic [6:0] C_FLALL  = 7'h11;
  localparam logic [6:0] C_FLALT  = 7'h13;
  localparam logic [6:0] C_CALL   = 7'h14;
  localparam logic [6:0] C_CALLF  = 7'h15;
  localparam logic [6:0] C_CONT   = 7'h17;
  localparam logic [6:0] C_LDMASK = 7'h20;
  localparam logic [6:0] C_LDROW  = 7'h30;
  localparam logic [6:0] C_LDCOL  = 7'h31;
  localparam logic [6:0] C_UPLOAD = 7'h4A;
  localparam logic [6:0] C_XFER   = 7'h50;
  localparam logic [6:0] C_XFERHL = 7'h51;

  typedef enum logic [3:0] {
    K_NOP, K_CYCLE, K_OFFSET, K_BASE, K_ITOP, K_MODE, K_PATH, K_MARK,
    K_WAITONLY, K_CALL, K_LDMASK, K_LDROW, K_LDCOL, K_LEN, K_BAD
  } kind_t;

  typedef struct packed {
    kind_t       kind;
    logic [2:0]  n_opnd;
    logic        need_vu;
    logic        need_gfx;
    logic        misplaced;
    logic [16:0] len;
  } cmd_info_t;

endpackage

// File: rtl/cdec_wfifo.sv
module cdec_wfifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32,
  parameter int PEEK  = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [W-1:0]             push_data,
  input  logic [2:0]               pop_n,
  output logic                     not_full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [PEEK-1:0][W-1:0]   peek
);
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push;

  assign not_full = (count < CNT_W'(DEPTH));
  assign do_push  = push && not_full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CNT_W'(do_push) - CNT_W'(pop_n);
    end
  end

  for (genvar i = 0; i < PEEK; i++) begin : g_peek
    assign peek[i] = mem[rd_ptr + AW'(i)];
  end

endmodule

// File: rtl/cdec_classify.sv
module cdec_classify
  import cdec_pkg::*;
#(
  parameter int UNIT = 1
) (
  input  logic [30:0] word,
  input  logic [1:0]  pos,
  output cmd_info_t   info
);
  localparam bit FULL_SET = (UNIT == 1);

  logic [6:0]  code;
  logic [7:0]  cnt;
  logic [15:0] imm;

  assign code = word[30:24];
  assign cnt  = word[23:16];
  assign imm  = word[15:0];

  always_comb begin
    info           = '0;
    info.kind      = K_BAD;
    case (code)
      C_NOP:    info.kind = K_NOP;
      C_CYCLE:  info.kind = K_CYCLE;
      C_OFFSET: info.kind = FULL_SET ? K_OFFSET : K_BAD;
      C_BASE:   info.kind = FULL_SET ? K_BASE : K_BAD;
      C_ITOP:   info.kind = K_ITOP;
      C_MODE:   info.kind = K_MODE;
      C_PATH:   info.kind = FULL_SET ? K_PATH : K_BAD;
      C_MARK:   info.kind = K_MARK;
      C_FLVU: begin
        info.kind    = K_WAITONLY;
        info.need_vu = 1'b1;
      end
      C_FLALL, C_FLALT: begin
        info.kind     = FULL_SET ? K_WAITONLY : K_BAD;
        info.need_vu  = 1'b1;
        info.need_gfx = 1'b1;
      end
      C_CALL: begin
        info.kind    = K_CALL;
        info.need_vu = 1'b1;
      end
      C_CALLF: begin
        info.kind     = FULL_SET ? K_CALL : K_BAD;
        info.need_vu  = 1'b1;
        info.need_gfx = 1'b1;
      end
      C_CONT: begin
        info.kind    = K_WAITONLY;
        info.need_vu = 1'b1;
      end
      C_LDMASK: begin
        info.kind   = K_LDMASK;
        info.n_opnd = 3'd1;
      end
      C_LDROW: begin
        info.kind   = K_LDROW;
        info.n_opnd = 3'd4;
      end
      C_LDCOL: begin
        info.kind   = K_LDCOL;
        info.n_opnd = 3'd4;
      end
      C_UPLOAD: begin
        info.kind      = K_LEN;
        info.misplaced = !(pos == 2'd1 || pos == 2'd3);
        info.len       = (cnt == 8'd0) ? 17'd256 : {9'd0, cnt};
      end
      C_XFER, C_XFERHL: begin
        info.kind      = K_LEN;
        info.misplaced = (pos != 2'd3);
        info.len       = (imm == 16'd0) ? 17'd65536 : {1'b0, imm};
      end
      default: info.kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/cmd_decode_engine.sv
module cmd_decode_engine
  import cdec_pkg::*;
#(
  parameter int UNIT       = 1,
  parameter int FIFO_DEPTH = 8,
  parameter int PTR_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  input  logic              irq_ack,
  input  logic              vu_busy,
  input  logic              gfx_busy,
  output logic [1:0]        pipe_state,
  output logic              irq_pend,
  output logic              err_pulse,
  output logic [PTR_W-1:0]  cmd_ptr,
  output logic [7:0]        cyc_wl,
  output logic [7:0]        cyc_cl,
  output logic [9:0]        ofs_val,
  output logic              dbuf_flag,
  output logic [9:0]        base_val,
  output logic [9:0]        itop_val,
  output logic [1:0]        mode_val,
  output logic [15:0]       mark_val,
  output logic              path3_mask,
  output logic [31:0]       mask_val,
  output logic [127:0]      row_val,
  output logic [127:0]      col_val,
  output logic [16:0]       xfer_len
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int N_PEEK = 5;

  pstate_t                 state, nstate;
  logic                    redo;
  logic [CNT_W-1:0]        fifo_cnt;
  logic [N_PEEK-1:0][31:0] peek;
  logic [2:0]              pop_n;
  cmd_info_t               info;
  logic [31:0]             head;
  logic [15:0]             imm;
  logic                    intr_eff, words_ok, busy_ok;
  logic                    do_exec, do_err, do_stall;

  cdec_wfifo #(.DEPTH(FIFO_DEPTH), .W(32), .PEEK(N_PEEK)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (in_data),
    .pop_n     (pop_n),
    .not_full  (in_ready),
    .count     (fifo_cnt),
    .peek      (peek)
  );

  assign head = peek[0];
  assign imm  = head[15:0];

  cdec_classify #(.UNIT(UNIT)) u_cls (
    .word (head[30:0]),
    .pos  (cmd_ptr[1:0]),
    .info (info)
  );

  assign intr_eff = head[31] && !redo;
  assign words_ok = (fifo_cnt > CNT_W'(info.n_opnd));
  assign busy_ok  = !(info.need_vu && vu_busy) && !(info.need_gfx && gfx_busy);

  always_comb begin
    nstate   = state;
    pop_n    = 3'd0;
    do_exec  = 1'b0;
    do_err   = 1'b0;
    do_stall = 1'b0;
    case (state)
      ST_IDLE: begin
        if (fifo_cnt != '0) nstate = ST_DECODE;
      end
      ST_DECODE, ST_WAIT: begin
        if (intr_eff) begin
          do_stall = 1'b1;
          nstate   = ST_STALL;
        end else if (info.kind == K_BAD || info.misplaced) begin
          do_err = 1'b1;
          pop_n  = 3'd1;
          nstate = ST_IDLE;
        end else if (!words_ok || !busy_ok) begin
          nstate = ST_WAIT;
        end else begin
          do_exec = 1'b1;
          pop_n   = 3'd1 + info.n_opnd;
          nstate  = ST_IDLE;
        end
      end
      ST_STALL: begin
        if (irq_ack) nstate = ST_DECODE;
      end
      default: nstate = ST_IDLE;
    endcase
  end

  // pipeline control and status
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      redo      <= 1'b0;
      irq_pend  <= 1'b0;
      err_pulse <= 1'b0;
      cmd_ptr   <= '0;
    end else begin
      state     <= nstate;
      err_pulse <= do_err;
      cmd_ptr   <= cmd_ptr + PTR_W'(pop_n);
      if (do_stall) irq_pend <= 1'b1;
      if (state == ST_STALL && irq_ack) begin
        irq_pend <= 1'b0;
        redo     <= 1'b1;
      end
      if (do_exec || do_err) redo <= 1'b0;
    end
  end

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_wl     <= '0;
      cyc_cl     <= '0;
      ofs_val    <= '0;
      dbuf_flag  <= 1'b0;
      base_val   <= '0;
      itop_val   <= '0;
      mode_val   <= '0;
      mark_val   <= '0;
      path3_mask <= 1'b0;
      mask_val   <= '0;
      row_val    <= '0;
      col_val    <= '0;
      xfer_len   <= '0;
    end else if (do_stall) begin
      if (info.kind == K_MARK) mark_val <= imm;
    end else if (do_exec) begin
      case (info.kind)
        K_CYCLE: begin
          cyc_wl <= imm[15:8];
          cyc_cl <= imm[7:0];
        end
        K_OFFSET: begin
          ofs_val   <= imm[9:0];
          dbuf_flag <= 1'b0;
        end
        K_BASE:   base_val   <= imm[9:0];
        K_ITOP:   itop_val   <= imm[9:0];
        K_MODE:   mode_val   <= imm[1:0];
        K_PATH:   path3_mask <= imm[15];
        K_MARK:   mark_val   <= imm;
        K_CALL:   dbuf_flag  <= ~dbuf_flag;
        K_LDMASK: mask_val   <= peek[1];
        K_LDROW:  row_val    <= {peek[4], peek[3], peek[2], peek[1]};
        K_LDCOL:  col_val    <= {peek[4], peek[3], peek[2], peek[1]};
        K_LEN:    xfer_len   <= info.len;
        default: ;
      endcase
    end
  end

  assign pipe_state = state;

endmodule

// File: rtl/cdec_checker.sv
module cdec_checker #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pipe_state,
  input logic             irq_pend,
  input logic             irq_ack,
  input logic             err_pulse,
  input logic [PTR_W-1:0] cmd_ptr,
  input logic [7:0]       cyc_wl
);

  p_stall_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_state == 2'd3) |-> irq_pend);

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_state == 2'd3) |=> ($stable(cmd_ptr) && $stable(cyc_wl)));

  p_ack_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_state == 2'd3 && irq_ack) |=> (pipe_state == 2'd1 && !irq_pend));

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_state == 2'd2) |-> $stable(cmd_ptr));

  p_err_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |=> !err_pulse);

  p_err_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (pipe_state == 2'd0));

endmodule

bind cmd_decode_engine cdec_checker #(.PTR_W(PTR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pipe_state (pipe_state),
  .irq_pend   (irq_pend),
  .irq_ack    (irq_ack),
  .err_pulse  (err_pulse),
  .cmd_ptr    (cmd_ptr),
  .cyc_wl     (cyc_wl)
);

// File: tb/sim_cmd_decode_engine.sv
module sim_cmd_decode_engine;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, in_valid, irq_ack, vu_busy, gfx_busy;
  logic [31:0] in_data;
  logic in_ready, irq_pend, err_pulse, dbuf_flag, path3_mask;
  logic [1:0] pipe_state, mode_val;
  logic [15:0] cmd_ptr, mark_val;
  logic [7:0] cyc_wl, cyc_cl;
  logic [9:0] ofs_val, base_val, itop_val;
  logic [31:0] mask_val;
  logic [127:0] row_val, col_val;
  logic [16:0] xfer_len;

  logic u1_valid;
  logic [31:0] u1_data;
  logic u1_ready, u1_pend, u1_err, u1_dbf, u1_p3;
  logic [1:0] u1_state, u1_mode;
  logic [15:0] u1_ptr, u1_mark;
  logic [7:0] u1_wl, u1_cl;
  logic [9:0] u1_ofs, u1_base, u1_itop;
  logic [31:0] u1_mask;
  logic [127:0] u1_row, u1_col;
  logic [16:0] u1_len;

  cmd_decode_engine #(.UNIT(1), .FIFO_DEPTH(DEPTH), .PTR_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .irq_ack(irq_ack), .vu_busy(vu_busy), .gfx_busy(gfx_busy), .pipe_state(pipe_state),
    .irq_pend(irq_pend), .err_pulse(err_pulse), .cmd_ptr(cmd_ptr), .cyc_wl(cyc_wl),
    .cyc_cl(cyc_cl), .ofs_val(ofs_val), .dbuf_flag(dbuf_flag), .base_val(base_val),
    .itop_val(itop_val), .mode_val(mode_val), .mark_val(mark_val), .path3_mask(path3_mask),
    .mask_val(mask_val), .row_val(row_val), .col_val(col_val), .xfer_len(xfer_len));

  cmd_decode_engine #(.UNIT(0), .FIFO_DEPTH(DEPTH), .PTR_W(16)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(u1_valid), .in_ready(u1_ready), .in_data(u1_data),
    .irq_ack(1'b0), .vu_busy(1'b0), .gfx_busy(1'b0), .pipe_state(u1_state),
    .irq_pend(u1_pend), .err_pulse(u1_err), .cmd_ptr(u1_ptr), .cyc_wl(u1_wl),
    .cyc_cl(u1_cl), .ofs_val(u1_ofs), .dbuf_flag(u1_dbf), .base_val(u1_base),
    .itop_val(u1_itop), .mode_val(u1_mode), .mark_val(u1_mark), .path3_mask(u1_p3),
    .mask_val(u1_mask), .row_val(u1_row), .col_val(u1_col), .xfer_len(u1_len));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // behavioural reference model of the unit-1 copy
  logic [31:0] m_q[$];
  int m_state = 0;
  bit m_pend = 0, m_redo = 0, m_err = 0, m_dbf = 0, m_p3 = 0;
  logic [15:0] m_ptr = 0, m_mark = 0;
  logic [7:0] m_wl = 0, m_cl = 0;
  logic [9:0] m_ofs = 0, m_base = 0, m_itop = 0;
  logic [1:0] m_mode = 0;
  logic [31:0] m_mask = 0;
  logic [127:0] m_row = 0, m_col = 0;
  logic [16:0] m_len = 0;

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    check("R2 pipe_state", 128'(pipe_state), 128'(m_state[1:0]));
    check("R2 cmd_ptr", 128'(cmd_ptr), 128'(m_ptr));
    check("R1 in_ready", 128'(in_ready), 128'(m_q.size() < DEPTH));
    check("R3 irq_pend", 128'(irq_pend), 128'(m_pend));
    check("R12 err_pulse", 128'(err_pulse), 128'(m_err));
    check("R6 cycle fields", 128'({cyc_wl, cyc_cl}), 128'({m_wl, m_cl}));
    check("R7 imm regs", 128'({ofs_val, base_val, itop_val, mode_val, path3_mask}),
          128'({m_ofs, m_base, m_itop, m_mode, m_p3}));
    check("R10 dbuf_flag", 128'(dbuf_flag), 128'(m_dbf));
    check("R4 mark_val", 128'(mark_val), 128'(m_mark));
    check("R9 mask_val", 128'(mask_val), 128'(m_mask));
    check("R9 row_val", row_val, m_row);
    check("R9 col_val", col_val, m_col);
    check("R11 xfer_len", 128'(xfer_len), 128'(m_len));
  endtask

  task automatic model_step(input bit v, input logic [31:0] d, input bit ack);
    int sz, popn, nxt, nop;
    bit acc, nerr, bad, mis, nvu, ngf;
    logic [31:0] w;
    logic [6:0] c;
    logic [15:0] im;
    logic [7:0] cn;
    logic [1:0] pos;
    sz = m_q.size(); popn = 0; nxt = m_state; nerr = 0;
    acc = v && (sz < DEPTH);
    case (m_state)
      0: if (sz > 0) nxt = 1;
      1, 2: begin
        w = m_q[0]; c = w[30:24]; im = w[15:0]; cn = w[23:16]; pos = m_ptr[1:0];
        nop = 0; bad = 0; mis = 0; nvu = 0; ngf = 0;
        case (c)
          7'h00, 7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h07: ;
          7'h10, 7'h14, 7'h17: nvu = 1;
          7'h11, 7'h13, 7'h15: begin nvu = 1; ngf = 1; end
          7'h20: nop = 1;
          7'h30, 7'h31: nop = 4;
          7'h4A: mis = !(pos == 2'd1 || pos == 2'd3);
          7'h50, 7'h51: mis = (pos != 2'd3);
          default: bad = 1;
        endcase
        if (w[31] && !m_redo) begin
          m_pend = 1; nxt = 3;
          if (c == 7'h07) m_mark = im;
        end else if (bad || mis) begin
          nerr = 1; popn = 1; nxt = 0; m_redo = 0;
        end else if (sz < 1 + nop || (nvu && vu_busy) || (ngf && gfx_busy)) begin
          nxt = 2;
        end else begin
          case (c)
            7'h01: begin m_wl = im[15:8]; m_cl = im[7:0]; end
            7'h02: begin m_ofs = im[9:0]; m_dbf = 0; end
            7'h03: m_base = im[9:0];
            7'h04: m_itop = im[9:0];
            7'h05: m_mode = im[1:0];
            7'h06: m_p3 = im[15];
            7'h07: m_mark = im;
            7'h14, 7'h15: m_dbf = !m_dbf;
            7'h20: m_mask = m_q[1];
            7'h30: m_row = {m_q[4], m_q[3], m_q[2], m_q[1]};
            7'h31: m_col = {m_q[4], m_q[3], m_q[2], m_q[1]};
            7'h4A: m_len = (cn == 0) ? 17'd256 : {9'd0, cn};
            7'h50, 7'h51: m_len = (im == 0) ? 17'd65536 : {1'b0, im};
            default: ;
          endcase
          popn = 1 + nop; nxt = 0; m_redo = 0;
        end
      end
      3: if (ack) begin m_pend = 0; m_redo = 1; nxt = 1; end
      default: ;
    endcase
    for (int i = 0; i < popn; i++) m_q.delete(0);
    if (acc) m_q.push_back(d);
    m_ptr = m_ptr + 16'(popn);
    m_err = nerr;
    m_state = nxt;
  endtask

  // one clock: compare, drive, advance model, move to next falling edge
  task automatic cyc(input bit v, input logic [31:0] d, input bit ack);
    compare();
    in_valid = v; in_data = d; irq_ack = ack;
    model_step(v, d, ack);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] d);
    bit acc;
    do begin
      acc = (m_q.size() < DEPTH);
      cyc(1'b1, d, 1'b0);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 32'd0, 1'b0);
  endtask

  task automatic drain();
    int g = 0;
    while ((m_state != 0 || m_q.size() != 0) && g < 500) begin
      cyc(1'b0, 32'd0, 1'b0);
      g++;
    end
  endtask

  function automatic logic [31:0] cw(input bit intr, input logic [6:0] code,
                                     input logic [7:0] cnt, input logic [15:0] imm);
    return {intr, code, cnt, imm};
  endfunction

  task automatic pad_to(input logic [1:0] p);
    drain();
    while (m_ptr[1:0] != p) begin
      send(cw(0, 7'h00, 0, 0));
      drain();
    end
  endtask

  task automatic count_err(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 32'd0, 1'b0);
      if (err_pulse) hits++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int hits;
    rst_n = 0; in_valid = 0; in_data = 0; irq_ack = 0; vu_busy = 0; gfx_busy = 0;
    u1_valid = 0; u1_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R2 reset state idle", 128'(pipe_state), 128'd0);
    check("R1 reset in_ready", 128'(in_ready), 128'd1);

    // R7 R6 immediate commands
    send(cw(0, 7'h00, 0, 16'h0000));
    send(cw(0, 7'h01, 0, 16'h0804));
    drain();
    check("R6 wl=8 cl=4", 128'({cyc_wl, cyc_cl}), 128'(16'h0804));
    send(cw(0, 7'h14, 0, 0));
    drain();
    check("R10 call toggles dbuf", 128'(dbuf_flag), 128'd1);
    send(cw(0, 7'h02, 0, 16'hFDFF));
    drain();
    check("R7 offset low bits", 128'(ofs_val), 128'(10'h1FF));
    check("R7 offset clears dbuf", 128'(dbuf_flag), 128'd0);
    send(cw(0, 7'h03, 0, 16'hFC12));
    send(cw(0, 7'h04, 0, 16'h0155));
    send(cw(0, 7'h05, 0, 16'hFFFE));
    send(cw(0, 7'h06, 0, 16'h8000));
    send(cw(0, 7'h07, 0, 16'h1234));
    drain();

    // R3 R5 interrupt on a non-marker command
    send(cw(1, 7'h01, 0, 16'h1122));
    idle(6);
    check("R3 stall state", 128'(pipe_state), 128'd3);
    check("R3 wl untouched", 128'(cyc_wl), 128'h08);
    cyc(1'b0, 0, 1'b1);
    idle(3);
    check("R5 re-decoded wl", 128'(cyc_wl), 128'h11);
    check("R5 pend cleared", 128'(irq_pend), 128'd0);

    // R4 interrupt on the marker command
    send(cw(1, 7'h07, 0, 16'hBEEF));
    idle(4);
    check("R4 stalled", 128'(pipe_state), 128'd3);
    check("R4 mark written during stall", 128'(mark_val), 128'hBEEF);
    cyc(1'b0, 0, 1'b1);
    drain();

    // R9 operand commands
    send(cw(0, 7'h20, 0, 0));
    idle(5);
    check("R9 waiting for mask operand", 128'(pipe_state), 128'd2);
    send(32'hA5A5_0F0F);
    drain();
    check("R9 mask loaded", 128'(mask_val), 128'hA5A5_0F0F);
    send(cw(0, 7'h30, 0, 0));
    send(32'h1111_0001); send(32'h2222_0002);
    idle(3);
    check("R9 row waiting", 128'(pipe_state), 128'd2);
    send(32'h3333_0003); send(32'h4444_0004);
    drain();
    check("R9 row order", row_val, 128'h4444_0004_3333_0003_2222_0002_1111_0001);
    send(cw(0, 7'h31, 0, 0));
    send(32'hC0); send(32'hC1); send(32'hC2); send(32'hC3);
    drain();

    // R10 busy waits
    vu_busy = 1;
    send(cw(0, 7'h10, 0, 0));
    idle(4);
    check("R10 vu flush held", 128'(pipe_state), 128'd2);
    vu_busy = 0;
    drain();
    gfx_busy = 1;
    send(cw(0, 7'h11, 0, 0));
    idle(3);
    check("R10 full flush held", 128'(pipe_state), 128'd2);
    gfx_busy = 0;
    send(cw(0, 7'h13, 0, 0));
    send(cw(0, 7'h15, 0, 0));
    send(cw(0, 7'h17, 0, 0));
    drain();

    // R11 alignment and length
    pad_to(2'd1);
    send(cw(0, 7'h4A, 8'd0, 0));
    drain();
    check("R11 upload count 0 is 256", 128'(xfer_len), 128'd256);
    send(cw(0, 7'h4A, 8'd5, 0));
    count_err(6, hits);
    check("R11 misplaced upload error", 128'(hits), 128'd1);
    pad_to(2'd3);
    send(cw(0, 7'h50, 0, 16'h0000));
    drain();
    check("R11 transfer 0 is 65536", 128'(xfer_len), 128'd65536);
    send(cw(0, 7'h51, 0, 16'h0010));
    count_err(6, hits);
    check("R11 misplaced transfer error", 128'(hits), 128'd1);

    // R12 undefined code
    send(cw(0, 7'h7F, 0, 16'h00AA));
    count_err(6, hits);
    check("R12 undefined code error", 128'(hits), 128'd1);

    // R1 back-pressure
    vu_busy = 1;
    send(cw(0, 7'h10, 0, 0));
    for (int i = 0; i < DEPTH - 1; i++) send(cw(0, 7'h00, 0, 0));
    idle(1);
    check("R1 in_ready low when full", 128'(in_ready), 128'd0);
    vu_busy = 0;
    drain();

    // R8 unit 0 variant
    u1_valid = 1; u1_data = cw(0, 7'h02, 0, 16'h0123);
    idle(1);
    u1_valid = 0;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      idle(1);
      if (u1_err) hits++;
    end
    check("R8 unit0 offset is error", 128'(hits), 128'd1);
    check("R8 unit0 offset untouched", 128'(u1_ofs), 128'd0);
    check("R8 unit0 word consumed", 128'(u1_ptr), 128'd1);
    u1_valid = 1; u1_data = cw(0, 7'h01, 0, 16'h0203);
    idle(1);
    u1_valid = 0;
    idle(6);
    check("R8 unit0 cycle legal", 128'({u1_wl, u1_cl}), 128'(16'h0203));
    u1_valid = 1; u1_data = cw(0, 7'h15, 0, 0);
    idle(1);
    u1_valid = 0;
    hits = 0;
    for (int i = 0; i < 6; i++) begin
      idle(1);
      if (u1_err) hits++;
    end
    check("R8 unit0 forced call error", 128'(hits), 128'd1);
    check("R8 unit0 dbuf untouched", 128'(u1_dbf), 128'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule